// File: doc/BRIEF.md
# Multiframe Boundary Event Generator

This block watches a transmit frame strobe that arrives once every 125 us. It raises single-cycle event pulses at the frame counts where a host has to refresh signalling or overhead data. A two-bit format input chooses between two T1 framing formats, 12-frame D4 and 24-frame ESF, and the 16-frame E1 format. Each format has its own multiframe length. In E1 there is also an event on every second frame, which marks the alternate-frame alignment point.

In either T1 format, a separate 72-frame superframe counter produces an SLC-96 event. An enable input gates that event but does not stop the counter. The pulses are combinational from registered counters, so each one is high during the very clock cycle in which the completing strobe is high.

A change of the format input clears every counter, so the first event after any restart comes a whole period later. One format code is left idle: it holds the counters at zero and produces nothing.

Top module: `mframe_evgen`

## Requirements
- R1: With `fmt` = 2'b00 (T1 D4), `mf_evt` pulses on every 12th accepted strobe: the 12th, the 24th and so on.
- R2: With `fmt` = 2'b01 (T1 ESF), `mf_evt` pulses on every 24th accepted strobe.
- R3: With `fmt` = 2'b10 (E1), `mf_evt` pulses on every 16th accepted strobe.
- R4: With `fmt` = 2'b10, `align_evt` pulses on every 2nd accepted strobe: the 2nd, the 4th and so on. It is never high in any other format.
- R5: With `fmt` = 2'b00 or 2'b01, a 72-strobe counter runs whatever the state of `slc_en`. `slc_evt` pulses on its 72nd strobe only if `slc_en` is high in that cycle. It is never high with `fmt` = 2'b10.
- R6: After reset all outputs are low and all counts restart, so the first event of each kind needs a full period of strobes.
- R7: Any change of `fmt` clears all counts. A strobe in the clock cycle where `fmt` differs from its value in the previous cycle is not counted and raises no event.
- R8: Each event is high only in the same clock cycle as the strobe that completes its period. It is never high without `frame_tick`.
- R9: With `fmt` = 2'b11 (idle), no event is ever raised and strobes are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle frame strobe, one per 125 us frame |
| fmt | input | 2 | Line format: 00 D4, 01 ESF, 10 E1, 11 idle |
| slc_en | input | 1 | Gates the 72-frame superframe event |
| mf_evt | output | 1 | Multiframe boundary pulse |
| align_evt | output | 1 | E1 alternate-frame alignment pulse |
| slc_evt | output | 1 | SLC-96 superframe pulse |

## Verification
The single-cycle pulse property assumes that `frame_tick` is never high in two consecutive cycles. This holds for a real frame strobe, because thousands of clocks separate two frames. The bench therefore always follows a strobe with at least two low cycles. The counter-bound property assumes that `fmt` stays stable except at deliberate mode switches. The bench changes `fmt` only on a falling edge, and most switches hold the new value for two cycles before the next strobe. One directed case deliberately puts a strobe in the switch cycle to show that it is dropped.

// File: rtl/mframe_evgen.sv
module mframe_evgen #(
  parameter int D4_LEN    = 12,
  parameter int ESF_LEN   = 24,
  parameter int E1_LEN    = 16,
  parameter int ALIGN_LEN = 2,
  parameter int SLC_LEN   = 72
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_tick,
  input  logic [1:0] fmt,
  input  logic       slc_en,
  output logic       mf_evt,
  output logic       align_evt,
  output logic       slc_evt
);

  localparam logic [1:0] FMT_D4   = 2'b00;
  localparam logic [1:0] FMT_ESF  = 2'b01;
  localparam logic [1:0] FMT_E1   = 2'b10;
  localparam logic [1:0] FMT_IDLE = 2'b11;

  localparam int MAX_T1 = (D4_LEN > ESF_LEN) ? D4_LEN : ESF_LEN;
  localparam int MAXLEN = (MAX_T1 > E1_LEN) ? MAX_T1 : E1_LEN;
  localparam int FW = $clog2(MAXLEN + 1);
  localparam int AW = $clog2(ALIGN_LEN + 1);
  localparam int SW = $clog2(SLC_LEN + 1);

  logic [1:0]    fmt_q;
  logic [FW-1:0] fcnt, period;
  logic [AW-1:0] acnt;
  logic [SW-1:0] scnt;
  logic          mode_chg, is_t1, is_e1, live;
  logic          f_wrap, a_wrap, s_wrap;

  assign mode_chg = fmt != fmt_q;
  assign is_t1    = (fmt == FMT_D4) || (fmt == FMT_ESF);
  assign is_e1    = fmt == FMT_E1;
  assign live     = frame_tick && !mode_chg && (fmt != FMT_IDLE);

  always_comb begin
    case (fmt)
      FMT_ESF: period = FW'(ESF_LEN);
      FMT_E1:  period = FW'(E1_LEN);
      default: period = FW'(D4_LEN);
    endcase
  end

  assign f_wrap = fcnt == period - FW'(1);
  assign a_wrap = acnt == AW'(ALIGN_LEN - 1);
  assign s_wrap = scnt == SW'(SLC_LEN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= FMT_D4;
      fcnt  <= '0;
      acnt  <= '0;
      scnt  <= '0;
    end else if (mode_chg) begin
      fmt_q <= fmt;
      fcnt  <= '0;
      acnt  <= '0;
      scnt  <= '0;
    end else if (live) begin
      fcnt <= f_wrap ? '0 : fcnt + FW'(1);
      if (is_e1) acnt <= a_wrap ? '0 : acnt + AW'(1);
      if (is_t1) scnt <= s_wrap ? '0 : scnt + SW'(1);
    end
  end

  assign mf_evt    = live && f_wrap;
  assign align_evt = live && is_e1 && a_wrap;
  assign slc_evt   = live && is_t1 && slc_en && s_wrap;

  assert_mf_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_evt || align_evt || slc_evt) |-> frame_tick);
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mf_evt |=> !mf_evt);
  assert_fcnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_chg |-> (fcnt < period));
  assert_align_only_e1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    align_evt |-> (fmt == FMT_E1));
  assert_slc_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slc_evt |-> (slc_en && fmt != FMT_E1 && fmt != FMT_IDLE));
  assert_clear_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (fcnt == '0 && acnt == '0 && scnt == '0));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_IDLE) |-> !(mf_evt || align_evt || slc_evt));

endmodule

// File: tb/test_mframe_evgen.sv
`timescale 1ns/1ps
module test_mframe_evgen;
  logic clk = 0, rst_n = 0, frame_tick = 0, slc_en = 0;
  logic [1:0] fmt = 2'b00;
  logic mf_evt, align_evt, slc_evt;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mframe_evgen i_mframe_evgen (.clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .fmt(fmt), .slc_en(slc_en), .mf_evt(mf_evt), .align_evt(align_evt), .slc_evt(slc_evt));

  typedef struct packed {
    logic [1:0] f; logic en; int n; int mf; int al; int slc;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{2'b00, 1'b1, 144, 12,  0, 2},
    '{2'b01, 1'b1, 150,  6,  0, 2},
    '{2'b10, 1'b1, 100,  6, 50, 0},
    '{2'b00, 1'b0,  80,  6,  0, 0},
    '{2'b01, 1'b0,  23,  0,  0, 0},
    '{2'b10, 1'b0,  33,  2, 16, 0},
    '{2'b00, 1'b1,  71,  5,  0, 0},
    '{2'b01, 1'b1,  72,  3,  0, 1}
  };

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(output logic m, output logic a, output logic s);
    @(negedge clk); frame_tick = 1;
    #2; m = mf_evt; a = align_evt; s = slc_evt;
    @(negedge clk); frame_tick = 0;
    @(negedge clk);
  endtask

  task automatic setmode(input logic [1:0] f);
    @(negedge clk); fmt = 2'b11;
    @(negedge clk); fmt = f;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic first_hit(input int n, input int which, output int idx);
    logic m, a, s;
    idx = 0;
    for (int i = 1; i <= n; i++) begin
      strobe(m, a, s);
      if (idx == 0 && ((which == 0 && m) || (which == 1 && a) || (which == 2 && s))) idx = i;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic m, a, s;
    int cm, ca, cs, idx;
    #1;
    chk(mf_evt, 0, "R6 mf in reset");
    chk(align_evt, 0, "R6 align in reset");
    chk(slc_evt, 0, "R6 slc in reset");
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      slc_en = TBL[v].en;
      setmode(TBL[v].f);
      cm = 0; ca = 0; cs = 0;
      for (int i = 0; i < TBL[v].n; i++) begin
        strobe(m, a, s);
        cm += int'(m); ca += int'(a); cs += int'(s);
      end
      chk(cm, TBL[v].mf, "R1 R2 R3 mf count");
      chk(ca, TBL[v].al, "R4 align count");
      chk(cs, TBL[v].slc, "R5 slc count");
    end

    // R6: reset mid-period, first D4 event on the 12th strobe
    slc_en = 1; setmode(2'b00);
    repeat (5) strobe(m, a, s);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    first_hit(12, 0, idx);
    chk(idx, 12, "R6 first mf after reset");

    // R3, R4: E1 first events
    setmode(2'b10);
    first_hit(2, 1, idx);
    chk(idx, 2, "R4 first align");
    setmode(2'b10);
    first_hit(16, 0, idx);
    chk(idx, 16, "R3 first E1 mf");

    // R2, R7: mid-period switch D4 -> ESF restarts
    setmode(2'b00);
    repeat (7) strobe(m, a, s);
    @(negedge clk); fmt = 2'b01; @(negedge clk); @(negedge clk);
    first_hit(24, 0, idx);
    chk(idx, 24, "R7 R2 first mf after switch");

    // R7: strobe in the change cycle is dropped
    setmode(2'b01);
    @(negedge clk); fmt = 2'b00; frame_tick = 1;
    #2; chk(mf_evt | align_evt | slc_evt, 0, "R7 event in change cycle");
    @(negedge clk); frame_tick = 0; @(negedge clk);
    first_hit(12, 0, idx);
    chk(idx, 12, "R7 change-cycle strobe not counted");

    // R5: counter runs while disabled
    slc_en = 0; setmode(2'b00);
    cs = 0;
    for (int i = 0; i < 70; i++) begin strobe(m, a, s); cs += int'(s); end
    chk(cs, 0, "R5 slc while disabled");
    slc_en = 1;
    strobe(m, a, s); chk(s, 0, "R5 slc at 71st");
    strobe(m, a, s); chk(s, 1, "R5 slc at 72nd");

    // R9: idle
    @(negedge clk); fmt = 2'b11; @(negedge clk); @(negedge clk);
    cm = 0;
    for (int i = 0; i < 80; i++) begin strobe(m, a, s); cm += int'(m) + int'(a) + int'(s); end
    chk(cm, 0, "R9 idle events");

    // R8: no event without strobe
    setmode(2'b00);
    repeat (11) strobe(m, a, s);
    @(negedge clk); #2;
    chk(mf_evt, 0, "R8 no mf without strobe");
    strobe(m, a, s);
    chk(m, 1, "R8 mf with completing strobe");
    @(negedge clk); #2;
    chk(mf_evt, 0, "R8 mf one cycle only");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule